// File: doc/BRIEF.md
# Per-Pad Request/Grant Pin Arbiter

This block decides which peripheral function owns each I/O pad. Every muxable peripheral raises one claim bit, which comes from that peripheral's own control register. For every pad, the arbiter looks at the claims from functions that a build-time eligibility mask allows on that pad. It picks the eligible claimant with the lowest function index and gives it a one-hot grant. It then steers that function's output value and output enable to the pad, and hands the pad's input level back to that function only.

Each pad also has a main (default) function. The main function drives the pad only when no eligible function is claiming it. Its path to the pad is a single 2:1 selection, so it never passes through the priority cascade. Grants are combinational from the claim bits. A function that loses a pad therefore loses its enable at that pad in the same cycle. A registered copy of the grant vector lets firmware confirm, one cycle later, that its claim was honoured.

Top module: `pinarb_top`

## Requirements
- R1: On every pad, at most one function is granted, and it is the lowest-index function that both requests and is eligible on that pad. Grant bit f*NUM_PADS+p belongs to function f on pad p.
- R2: A function whose eligibility bit CLAIM_MASK[f*NUM_PADS+p] is 0 is never granted pad p, whatever its request.
- R3: Grants, pad outputs and steered inputs follow a change of requests in the same cycle, with no clock edge in between.
- R4: While function f holds pad p, pad_out[p] and pad_oe[p] equal that function's output value and enable for pad p. The enables of non-granted functions do not reach the pad.
- R5: When no eligible function requests pad p, main_own[p] is 1 and pad_out[p] and pad_oe[p] follow main_out[p] and main_oe[p].
- R6: func_in for a granted function carries pad_in of that pad. A function without the grant sees its idle level FUNC_IDLE[f] (default 4'b1011, so function 2 idles low).
- R7: main_in[p] carries pad_in[p] while the main function owns the pad, and MAIN_IDLE (default 1) otherwise.
- R8: gnt_status is 0 after a clock edge with rst high. After any other edge, it holds the grant vector present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the status register |
| func_req | input | NUM_FUNCS | Per-function pad claim bit |
| func_out | input | NUM_FUNCS*NUM_PADS | Output value per function and pad (bit f*NUM_PADS+p) |
| func_oe | input | NUM_FUNCS*NUM_PADS | Output enable per function and pad |
| func_in | output | NUM_FUNCS*NUM_PADS | Pad input as seen by each function, or its idle level |
| func_gnt | output | NUM_FUNCS*NUM_PADS | Combinational one-hot grant per pad |
| gnt_status | output | NUM_FUNCS*NUM_PADS | Registered grant vector |
| main_out | input | NUM_PADS | Main function output value |
| main_oe | input | NUM_PADS | Main function output enable |
| main_in | output | NUM_PADS | Pad input as seen by the main function |
| main_own | output | NUM_PADS | High when the main function owns the pad |
| pad_out | output | NUM_PADS | Value to the pad cell |
| pad_oe | output | NUM_PADS | Enable to the pad cell |
| pad_in | input | NUM_PADS | Level from the pad cell |

## Verification
Random claim vectors with random data and enables exercise the common case, where several functions contend for one pad. That case separates correct priority order from a reversed order or a dropped eligibility bit. Directed patterns cover four further cases: no claims at all (main ownership and the bypass path), every function claiming (only the top-priority eligible function wins each pad), claims from functions that are ineligible on a pad (these must leave the main function in control), and a claim dropped between two cycles (the enable is released at once and the status register lags by exactly one edge).

// File: rtl/pinarb_pkg.sv
package pinarb_pkg;
  // Flat index of the (function, pad) slot in every per-slot vector.
  function automatic int unsigned slot_idx(input int unsigned f, input int unsigned p,
                                           input int unsigned num_pads);
    return f * num_pads + p;
  endfunction
endpackage

// File: rtl/pinarb_prio.sv
// Fixed-priority picker: lowest index wins, output one-hot or zero.
module pinarb_prio #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] gnt,
  output logic             any
);
  logic [WIDTH:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign gnt[i]         = req[i] & ~blocked[i];
    assign blocked[i + 1] = blocked[i] | req[i];
  end
  assign any = blocked[WIDTH];
endmodule

// File: rtl/pinarb_steer.sv
// Per-pad steering: AND-OR merge of alternates, then one 2:1 level against main.
module pinarb_steer #(
  parameter int                   NUM_FUNCS = 4,
  parameter logic [NUM_FUNCS-1:0] FUNC_IDLE = '1,
  parameter logic                 MAIN_IDLE = 1'b1
) (
  input  logic [NUM_FUNCS-1:0] gnt,
  input  logic                 alt_busy,
  input  logic [NUM_FUNCS-1:0] alt_out,
  input  logic [NUM_FUNCS-1:0] alt_oe,
  output logic [NUM_FUNCS-1:0] alt_in,
  input  logic                 main_out,
  input  logic                 main_oe,
  output logic                 main_in,
  output logic                 pad_out,
  output logic                 pad_oe,
  input  logic                 pad_in
);
  logic alt_val;
  logic alt_en;

  // Grants are one-hot, so an AND-OR tree replaces a mux cascade.
  assign alt_val = |(gnt & alt_out);
  assign alt_en  = |(gnt & alt_oe);

  // Main function bypass: one selection level to the pad.
  always_comb begin
    if (alt_busy) begin
      pad_out = alt_val;
      pad_oe  = alt_en;
      main_in = MAIN_IDLE;
    end else begin
      pad_out = main_out;
      pad_oe  = main_oe;
      main_in = pad_in;
    end
  end

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_in
    assign alt_in[f] = gnt[f] ? pad_in : FUNC_IDLE[f];
  end
endmodule

// File: rtl/pinarb_top.sv
module pinarb_top
  import pinarb_pkg::*;
#(
  parameter int NUM_PADS  = 4,
  parameter int NUM_FUNCS = 4,
  parameter logic [NUM_FUNCS*NUM_PADS-1:0] CLAIM_MASK = 16'hB7ED,
  parameter logic [NUM_FUNCS-1:0]          FUNC_IDLE  = 4'b1011,
  parameter logic                          MAIN_IDLE  = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_FUNCS-1:0]          func_req,
  input  logic [NUM_FUNCS*NUM_PADS-1:0] func_out,
  input  logic [NUM_FUNCS*NUM_PADS-1:0] func_oe,
  output logic [NUM_FUNCS*NUM_PADS-1:0] func_in,
  output logic [NUM_FUNCS*NUM_PADS-1:0] func_gnt,
  output logic [NUM_FUNCS*NUM_PADS-1:0] gnt_status,
  input  logic [NUM_PADS-1:0]           main_out,
  input  logic [NUM_PADS-1:0]           main_oe,
  output logic [NUM_PADS-1:0]           main_in,
  output logic [NUM_PADS-1:0]           main_own,
  output logic [NUM_PADS-1:0]           pad_out,
  output logic [NUM_PADS-1:0]           pad_oe,
  input  logic [NUM_PADS-1:0]           pad_in
);
  localparam int SLOTS = NUM_FUNCS * NUM_PADS;

  logic [SLOTS-1:0]    gnt_all;
  logic [NUM_PADS-1:0] alt_busy;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic [NUM_FUNCS-1:0] req_p;
    logic [NUM_FUNCS-1:0] gnt_p;
    logic [NUM_FUNCS-1:0] aout_p;
    logic [NUM_FUNCS-1:0] aoe_p;
    logic [NUM_FUNCS-1:0] ain_p;

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
      localparam int unsigned IDX = slot_idx(f, p, NUM_PADS);
      assign req_p[f]     = func_req[f] & CLAIM_MASK[IDX];
      assign aout_p[f]    = func_out[IDX];
      assign aoe_p[f]     = func_oe[IDX];
      assign gnt_all[IDX] = gnt_p[f];
      assign func_in[IDX] = ain_p[f];
    end

    pinarb_prio #(.WIDTH(NUM_FUNCS)) u_prio (
      .req (req_p),
      .gnt (gnt_p),
      .any (alt_busy[p])
    );

    pinarb_steer #(
      .NUM_FUNCS (NUM_FUNCS),
      .FUNC_IDLE (FUNC_IDLE),
      .MAIN_IDLE (MAIN_IDLE)
    ) u_steer (
      .gnt      (gnt_p),
      .alt_busy (alt_busy[p]),
      .alt_out  (aout_p),
      .alt_oe   (aoe_p),
      .alt_in   (ain_p),
      .main_out (main_out[p]),
      .main_oe  (main_oe[p]),
      .main_in  (main_in[p]),
      .pad_out  (pad_out[p]),
      .pad_oe   (pad_oe[p]),
      .pad_in   (pad_in[p])
    );
  end

  assign func_gnt = gnt_all;
  assign main_own = ~alt_busy;

  always_ff @(posedge clk) begin
    if (rst) gnt_status <= '0;
    else     gnt_status <= gnt_all;
  end
endmodule

// File: rtl/pinarb_chk.sv
module pinarb_chk
  import pinarb_pkg::*;
#(
  parameter int NUM_PADS  = 4,
  parameter int NUM_FUNCS = 4,
  parameter logic [NUM_FUNCS*NUM_PADS-1:0] CLAIM_MASK = 16'hB7ED,
  parameter logic [NUM_FUNCS-1:0]          FUNC_IDLE  = 4'b1011,
  parameter logic                          MAIN_IDLE  = 1'b1
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_FUNCS-1:0]          func_req,
  input logic [NUM_FUNCS*NUM_PADS-1:0] func_out,
  input logic [NUM_FUNCS*NUM_PADS-1:0] func_oe,
  input logic [NUM_FUNCS*NUM_PADS-1:0] func_in,
  input logic [NUM_FUNCS*NUM_PADS-1:0] func_gnt,
  input logic [NUM_FUNCS*NUM_PADS-1:0] gnt_status,
  input logic [NUM_PADS-1:0]           main_out,
  input logic [NUM_PADS-1:0]           main_oe,
  input logic [NUM_PADS-1:0]           main_in,
  input logic [NUM_PADS-1:0]           main_own,
  input logic [NUM_PADS-1:0]           pad_out,
  input logic [NUM_PADS-1:0]           pad_oe,
  input logic [NUM_PADS-1:0]           pad_in
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic [NUM_FUNCS-1:0] gnt_p;
    logic [NUM_FUNCS-1:0] elig_req_p;
    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
      localparam int unsigned IDX = slot_idx(f, p, NUM_PADS);
      assign gnt_p[f]      = func_gnt[IDX];
      assign elig_req_p[f] = func_req[f] & CLAIM_MASK[IDX];

      // R1: no eligible lower-index requester may exist beside a grant
      if (f > 0) begin : g_lower
        p_priority_r1: assert property (@(posedge clk) disable iff (rst)
          func_gnt[IDX] |-> (elig_req_p[f-1:0] == '0));
      end

      // R2: ineligible slots stay ungranted even when requesting
      if (!CLAIM_MASK[IDX]) begin : g_inelig
        p_inelig_r2: assert property (@(posedge clk) disable iff (rst)
          func_req[f] |-> !func_gnt[IDX]);
      end

      // R4: granted function drives the pad
      p_route_r4: assert property (@(posedge clk) disable iff (rst)
        func_gnt[IDX] |-> (pad_out[p] == func_out[IDX] && pad_oe[p] == func_oe[IDX]));

      // R6: input steering
      p_in_gnt_r6: assert property (@(posedge clk) disable iff (rst)
        func_gnt[IDX] |-> (func_in[IDX] == pad_in[p]));
      p_in_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !func_gnt[IDX] |-> (func_in[IDX] == FUNC_IDLE[f]));
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt_p));

    // R5: main ownership means no grant and the main path reaches the pad
    p_main_r5: assert property (@(posedge clk) disable iff (rst)
      main_own[p] |-> (gnt_p == '0 && pad_out[p] == main_out[p] && pad_oe[p] == main_oe[p]));
    p_claim_r5: assert property (@(posedge clk) disable iff (rst)
      (elig_req_p != '0) |-> !main_own[p]);

    // R7: main input steering
    p_main_in_r7: assert property (@(posedge clk) disable iff (rst)
      main_in[p] == (main_own[p] ? pad_in[p] : MAIN_IDLE));
  end

  // R8: status lags the grant by one edge
  p_status_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (gnt_status == $past(func_gnt)));
endmodule

bind pinarb_top pinarb_chk #(
  .NUM_PADS   (NUM_PADS),
  .NUM_FUNCS  (NUM_FUNCS),
  .CLAIM_MASK (CLAIM_MASK),
  .FUNC_IDLE  (FUNC_IDLE),
  .MAIN_IDLE  (MAIN_IDLE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .func_req   (func_req),
  .func_out   (func_out),
  .func_oe    (func_oe),
  .func_in    (func_in),
  .func_gnt   (func_gnt),
  .gnt_status (gnt_status),
  .main_out   (main_out),
  .main_oe    (main_oe),
  .main_in    (main_in),
  .main_own   (main_own),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pad_in     (pad_in)
);

// File: tb/pinarb_top_tb.sv
`timescale 1ns/1ps
module pinarb_top_tb;
  localparam int NP = 4;
  localparam int NF = 4;
  localparam int SL = NP * NF;
  localparam logic [SL-1:0] MASK   = 16'hB7ED;
  localparam logic [NF-1:0] F_IDLE = 4'b1011;
  localparam logic          M_IDLE = 1'b1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NF-1:0] func_req = '0;
  logic [SL-1:0] func_out = '0, func_oe = '0;
  logic [SL-1:0] func_in, func_gnt, gnt_status;
  logic [NP-1:0] main_out = '0, main_oe = '0, pad_in = '0;
  logic [NP-1:0] main_in, main_own, pad_out, pad_oe;

  int n_chk  = 0;
  int n_fail = 0;
  logic [SL-1:0] prev_gnt;
  bit have_prev = 0;

  always #2.5 clk = ~clk;

  pinarb_top #(.NUM_PADS(NP), .NUM_FUNCS(NF), .CLAIM_MASK(MASK),
               .FUNC_IDLE(F_IDLE), .MAIN_IDLE(M_IDLE)) u_dut (
    .clk(clk), .rst(rst), .func_req(func_req), .func_out(func_out),
    .func_oe(func_oe), .func_in(func_in), .func_gnt(func_gnt),
    .gnt_status(gnt_status), .main_out(main_out), .main_oe(main_oe),
    .main_in(main_in), .main_own(main_own), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_in(pad_in));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference grant: lowest eligible requesting index per pad.
  function automatic logic [SL-1:0] ref_gnt(input logic [NF-1:0] req);
    logic [SL-1:0] g = '0;
    for (int p = 0; p < NP; p++) begin
      bit taken = 0;
      for (int f = 0; f < NF; f++)
        if (!taken && req[f] && MASK[f*NP+p]) begin
          g[f*NP+p] = 1'b1;
          taken = 1;
        end
    end
    return g;
  endfunction

  task automatic apply(input logic [NF-1:0] rq, input logic [SL-1:0] fo,
                       input logic [SL-1:0] foe, input logic [NP-1:0] mo,
                       input logic [NP-1:0] moe, input logic [NP-1:0] pin);
    logic [SL-1:0] g;
    logic [SL-1:0] e_fin;
    logic [NP-1:0] e_po, e_poe, e_mi, e_own;
    @(negedge clk);
    if (have_prev) chk("R8 status lags grant", gnt_status, prev_gnt);
    func_req = rq; func_out = fo; func_oe = foe;
    main_out = mo; main_oe = moe; pad_in = pin;
    #1;
    g = ref_gnt(rq);
    for (int p = 0; p < NP; p++) begin
      e_own[p] = 1'b1; e_po[p] = mo[p]; e_poe[p] = moe[p]; e_mi[p] = pin[p];
      for (int f = 0; f < NF; f++) begin
        int i = f * NP + p;
        e_fin[i] = g[i] ? pin[p] : F_IDLE[f];
        if (g[i]) begin
          e_own[p] = 1'b0; e_po[p] = fo[i]; e_poe[p] = foe[i]; e_mi[p] = M_IDLE;
        end
      end
    end
    // R3: all of these are sampled in the cycle the requests change
    chk("R1 R2 R3 grant", func_gnt, g);
    chk("R4 R5 pad_out", pad_out, e_po);
    chk("R4 R5 pad_oe", pad_oe, e_poe);
    chk("R5 main_own", main_own, e_own);
    chk("R6 func_in", func_in, e_fin);
    chk("R7 main_in", main_in, e_mi);
    prev_gnt = g;
    have_prev = 1;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    func_req = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset status", gnt_status, '0);
    rst = 1'b0;

    // R5: no claims, main owns every pad
    apply('0, 16'hFFFF, 16'hFFFF, 4'b1010, 4'b0110, 4'b1100);
    // R1: every function claims
    apply('1, 16'h5A5A, 16'hFFFF, 4'b0000, 4'b0000, 4'b1011);
    // R2: claims only from functions ineligible on pad 3 (func 2)
    apply(4'b0100, 16'hFFFF, 16'hFFFF, 4'b0101, 4'b1111, 4'b0101);
    // R4: drop the winner, next function takes over with its own enable
    apply(4'b0011, 16'h0F0F, 16'h00F0, 4'b1111, 4'b1111, 4'b0011);
    apply(4'b0010, 16'h0F0F, 16'h00F0, 4'b1111, 4'b1111, 4'b0011);
    apply('0, 16'h0F0F, 16'h00F0, 4'b0000, 4'b0000, 4'b0000);
    // R6: idle-low function 2 alone
    apply(4'b0100, 16'h0000, 16'h0000, 4'b0000, 4'b0000, 4'b1111);

    for (int k = 0; k < 400; k++)
      apply(NF'($urandom), SL'($urandom), SL'($urandom),
            NP'($urandom), NP'($urandom), NP'($urandom));

    apply('0, '0, '0, '0, '0, '0);
    @(negedge clk);
    chk("R8 final status", gnt_status, prev_gnt);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule